// File: doc/BRIEF.md
# Ternary-Match Action Selector

This block chooses a control action from a snapshot of monitored system state. It holds a small table of rules. Each rule has a ternary condition, an action code and a small fitness score. When an evaluation is requested, the block latches the state vector. It then compares the vector with every live rule, where a condition bit may demand a 0, demand a 1, or accept either value. One matching rule is picked, and its action is driven out together with a valid flag.

Two pick strategies are available. The first takes the matching rule with the highest fitness. The second is a fitness-weighted random draw: a pseudo-random value below the total fitness of the matching rules is drawn, and the matching rules are then walked one per clock until the running fitness sum passes the draw. After the chosen action has been applied, a reward strobe moves the fitness of the rule that produced it up or down by one. In this way rules that give good outcomes win more often. Rules are loaded through a simple write port while no evaluation is running.

Top module: `ternary_action_selector`

## Requirements
- R1: After reset no rule is live, `act_valid` and `busy` are 0, and an evaluation completes with `act_nomatch` = 1 and `act_out` = 0.
- R2: A live rule matches when `((state XOR value) AND care) == 0`. The state vector is laid out as frequency [7:5], utilization [4:2] and workload difference [1:0]. A care bit of 0 makes that position a wildcard.
- R3: With `pick_mode` = 0, the matching rule with the highest fitness is chosen, and on equal fitness the lowest index wins. `act_out` carries that rule's action (frequency setting [4:1], migrate request [0]) and `act_rule` carries its index. In this mode `act_valid` rises by the second clock edge after `eval_go` is sampled.
- R4: If no live rule matches, or if in `pick_mode` = 1 every matching rule has fitness 0, the result is `act_valid` = 1, `act_nomatch` = 1 and `act_out` = 0.
- R5: With `pick_mode` = 1, a matching rule is drawn with probability proportional to its fitness. A rule with fitness 0 is never chosen, and the result is ready within N_RULES + 2 cycles.
- R6: A `reward_go` strobe seen while idle, with a pending result that matched, adds 1 to the fitness of the chosen rule (`reward_pos` = 1) or subtracts 1 from it (`reward_pos` = 0). Only one reward is applied per result, and any further strobe is ignored.
- R7: Fitness saturates at 15 and at 0, and never wraps.
- R8: A write (`wr_en`) is accepted only in a cycle where `busy` is 0. It makes the rule at `wr_idx` live with the given value, care, action and initial fitness. A write seen while `busy` is 1 has no effect.
- R9: While an evaluation runs, `busy` is 1 and `act_valid` is 0, and a further `eval_go` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_state | input | 8 | Monitored state vector, sampled on `eval_go` |
| pick_mode | input | 1 | 0 = highest fitness, 1 = fitness-weighted draw; sampled on `eval_go` |
| eval_go | input | 1 | Start an evaluation |
| reward_go | input | 1 | Apply a reward to the last chosen rule |
| reward_pos | input | 1 | 1 = positive reward, 0 = negative reward |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | 4 | Rule index to write |
| wr_value | input | 8 | Condition value bits |
| wr_care | input | 8 | Condition care bits (1 = compared) |
| wr_action | input | 5 | Action code of the rule |
| wr_fitness | input | 4 | Initial fitness |
| busy | output | 1 | Evaluation in progress |
| act_valid | output | 1 | Result available; held until the next evaluation starts |
| act_nomatch | output | 1 | Result is the default action |
| act_out | output | 5 | Chosen action |
| act_rule | output | 4 | Index of the chosen rule |

## Verification
Several state vectors are applied to one table. One vector hits every rule, one hits only through wildcard positions, and one differs from a rule in a single cared bit. Together they separate correct ternary comparison from exact or inverted matching. Equal-fitness pairs and one-step reward sequences show whether ties go to the lowest index and whether a second reward strobe is dropped. Rules at fitness 15 and 0 expose wrap-around. In random-draw mode, repeated draws over a 12/0/4 fitness mix must never return the zero-fitness rule and must favour the heavier rule. A zero-total case separates random-draw mode, which gives no match, from highest-fitness mode, which still picks the rule.

// File: rtl/tas_pkg.sv
package tas_pkg;

    localparam int STATE_W  = 8;
    localparam int ACT_W    = 5;
    localparam int FIT_W    = 4;
    localparam int LFSR_W   = 16;
    localparam int DRAW_W   = 8;

    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    localparam logic [ACT_W-1:0]  DEFAULT_ACT = '0;

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [ACT_W-1:0]   act_t;
    typedef logic [FIT_W-1:0]   fit_t;

    localparam fit_t FIT_MAX = '1;

    typedef struct packed {
        logic   live;
        state_t value;
        state_t care;
        act_t   action;
        fit_t   fitness;
    } rule_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_WALK = 2'd2
    } phase_e;

    typedef enum logic {
        SEL_TOP   = 1'b0,
        SEL_WHEEL = 1'b1
    } sel_e;

    function automatic logic cond_hit(state_t s, state_t v, state_t c);
        return ((s ^ v) & c) == '0;
    endfunction

    function automatic fit_t fit_step(fit_t f, logic up);
        if (up)
            return (f == FIT_MAX) ? f : f + 1'b1;
        else
            return (f == '0) ? f : f - 1'b1;
    endfunction

endpackage

// File: rtl/tas_rule_bank.sv
module tas_rule_bank
    import tas_pkg::*;
#(
    parameter int N_RULES = 16,
    localparam int IDX_W = $clog2(N_RULES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  state_t                   wr_value,
    input  state_t                   wr_care,
    input  act_t                     wr_action,
    input  fit_t                     wr_fitness,
    input  logic                     upd_en,
    input  logic [IDX_W-1:0]         upd_idx,
    input  logic                     upd_up,
    input  state_t                   probe,
    output logic [N_RULES-1:0]       hit_vec,
    output fit_t [N_RULES-1:0]       fit_vec,
    output act_t [N_RULES-1:0]       act_vec
);

    for (genvar g = 0; g < N_RULES; g++) begin : g_rule
        rule_t r;

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                r.live    <= 1'b1;
                r.value   <= wr_value;
                r.care    <= wr_care;
                r.action  <= wr_action;
                r.fitness <= wr_fitness;
            end else if (upd_en && upd_idx == IDX_W'(g)) begin
                r.fitness <= fit_step(r.fitness, upd_up);
            end
        end

        assign hit_vec[g] = r.live && cond_hit(probe, r.value, r.care);
        assign fit_vec[g] = r.fitness;
        assign act_vec[g] = r.action;
    end

endmodule

// File: rtl/tas_top_pick.sv
module tas_top_pick
    import tas_pkg::*;
#(
    parameter int N_RULES = 16,
    localparam int IDX_W = $clog2(N_RULES)
) (
    input  logic [N_RULES-1:0]  hit_vec,
    input  fit_t [N_RULES-1:0]  fit_vec,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);

    fit_t best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N_RULES; i++) begin
            if (hit_vec[i] && (!found || fit_vec[i] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = fit_vec[i];
            end
        end
    end

endmodule

// File: rtl/tas_lfsr.sv
module tas_lfsr
    import tas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [DRAW_W-1:0] rnd
);

    logic [LFSR_W-1:0] s;

    always_ff @(posedge clk) begin
        if (rst)
            s <= LFSR_SEED;
        else if (s[0])
            s <= (s >> 1) ^ LFSR_TAPS;
        else
            s <= s >> 1;
    end

    assign rnd = s[LFSR_W-1 -: DRAW_W];

endmodule

// File: rtl/ternary_action_selector.sv
module ternary_action_selector
    import tas_pkg::*;
#(
    parameter int N_RULES = 16,
    localparam int IDX_W = $clog2(N_RULES),
    localparam int SUM_W = FIT_W + IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [STATE_W-1:0]  mon_state,
    input  logic                pick_mode,
    input  logic                eval_go,
    input  logic                reward_go,
    input  logic                reward_pos,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [STATE_W-1:0]  wr_value,
    input  logic [STATE_W-1:0]  wr_care,
    input  logic [ACT_W-1:0]    wr_action,
    input  logic [FIT_W-1:0]    wr_fitness,
    output logic                busy,
    output logic                act_valid,
    output logic                act_nomatch,
    output logic [ACT_W-1:0]    act_out,
    output logic [IDX_W-1:0]    act_rule
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_RULES - 1);

    phase_e             phase;
    sel_e               mode_q;
    state_t             cap_state;
    logic               pend;
    logic [IDX_W-1:0]   walk_idx;
    logic [SUM_W-1:0]   acc;
    logic [SUM_W-1:0]   acc_next;
    logic [SUM_W-1:0]   draw;
    logic [SUM_W-1:0]   draw_calc;
    logic [SUM_W-1:0]   wheel_sum;
    logic [DRAW_W+SUM_W-1:0] prod;

    logic [N_RULES-1:0] hit_vec;
    fit_t [N_RULES-1:0] fit_vec;
    act_t [N_RULES-1:0] act_vec;
    logic               top_found;
    logic [IDX_W-1:0]   top_idx;
    logic [DRAW_W-1:0]  rnd;

    logic               wr_ok;
    logic               upd_fire;

    assign busy     = (phase != PH_IDLE);
    assign wr_ok    = wr_en && !busy;
    assign upd_fire = reward_go && pend && !busy;

    tas_rule_bank #(.N_RULES(N_RULES)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_ok),
        .wr_idx     (wr_idx),
        .wr_value   (wr_value),
        .wr_care    (wr_care),
        .wr_action  (wr_action),
        .wr_fitness (wr_fitness),
        .upd_en     (upd_fire),
        .upd_idx    (act_rule),
        .upd_up     (reward_pos),
        .probe      (cap_state),
        .hit_vec    (hit_vec),
        .fit_vec    (fit_vec),
        .act_vec    (act_vec)
    );

    tas_top_pick #(.N_RULES(N_RULES)) u_pick (
        .hit_vec (hit_vec),
        .fit_vec (fit_vec),
        .found   (top_found),
        .idx     (top_idx)
    );

    tas_lfsr u_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    // Total fitness of the matching rules: the width of the wheel.
    always_comb begin
        wheel_sum = '0;
        for (int i = 0; i < N_RULES; i++)
            if (hit_vec[i])
                wheel_sum = wheel_sum + SUM_W'(fit_vec[i]);
    end

    // Scale the random byte onto [0, wheel_sum).
    assign prod      = (DRAW_W+SUM_W)'(rnd) * (DRAW_W+SUM_W)'(wheel_sum);
    assign draw_calc = SUM_W'(prod >> DRAW_W);
    assign acc_next  = acc + (hit_vec[walk_idx] ? SUM_W'(fit_vec[walk_idx]) : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            mode_q      <= SEL_TOP;
            cap_state   <= '0;
            pend        <= 1'b0;
            walk_idx    <= '0;
            acc         <= '0;
            draw        <= '0;
            act_valid   <= 1'b0;
            act_nomatch <= 1'b0;
            act_out     <= DEFAULT_ACT;
            act_rule    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (upd_fire)
                        pend <= 1'b0;
                    if (eval_go) begin
                        cap_state   <= mon_state;
                        mode_q      <= sel_e'(pick_mode);
                        pend        <= 1'b0;
                        act_valid   <= 1'b0;
                        act_nomatch <= 1'b0;
                        phase       <= PH_SCAN;
                    end
                end
                PH_SCAN: begin
                    if (mode_q == SEL_TOP) begin
                        phase     <= PH_IDLE;
                        act_valid <= 1'b1;
                        if (top_found) begin
                            act_out  <= act_vec[top_idx];
                            act_rule <= top_idx;
                            pend     <= 1'b1;
                        end else begin
                            act_out     <= DEFAULT_ACT;
                            act_rule    <= '0;
                            act_nomatch <= 1'b1;
                        end
                    end else if (wheel_sum == '0) begin
                        phase       <= PH_IDLE;
                        act_valid   <= 1'b1;
                        act_out     <= DEFAULT_ACT;
                        act_rule    <= '0;
                        act_nomatch <= 1'b1;
                    end else begin
                        draw     <= draw_calc;
                        acc      <= '0;
                        walk_idx <= '0;
                        phase    <= PH_WALK;
                    end
                end
                PH_WALK: begin
                    if (hit_vec[walk_idx] && acc_next > draw) begin
                        phase     <= PH_IDLE;
                        act_valid <= 1'b1;
                        act_out   <= act_vec[walk_idx];
                        act_rule  <= walk_idx;
                        pend      <= 1'b1;
                    end else if (walk_idx == LAST_IDX) begin
                        phase       <= PH_IDLE;
                        act_valid   <= 1'b1;
                        act_out     <= DEFAULT_ACT;
                        act_rule    <= '0;
                        act_nomatch <= 1'b1;
                    end else begin
                        acc      <= acc_next;
                        walk_idx <= walk_idx + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tas_checker.sv
module tas_checker
    import tas_pkg::*;
#(
    parameter int N_RULES = 16,
    localparam int IDX_W = $clog2(N_RULES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                busy,
    input  logic                act_valid,
    input  logic                act_nomatch,
    input  logic [IDX_W-1:0]    act_rule,
    input  logic [N_RULES-1:0]  hit_vec,
    input  fit_t [N_RULES-1:0]  fit_vec,
    input  logic                mode_q,
    input  logic                wr_ok
);

    a_r4_nomatch_has_valid: assert property (@(posedge clk) disable iff (rst)
        act_nomatch |-> act_valid);

    a_r9_busy_hides_result: assert property (@(posedge clk) disable iff (rst)
        busy |-> !act_valid);

    a_r2_winner_matches: assert property (@(posedge clk) disable iff (rst)
        ($rose(act_valid) && !act_nomatch) |-> hit_vec[act_rule]);

    a_r5_wheel_skips_zero: assert property (@(posedge clk) disable iff (rst)
        ($rose(act_valid) && !act_nomatch && mode_q) |-> (fit_vec[act_rule] != '0));

    a_r8_busy_freezes_table: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(fit_vec));

    for (genvar g = 0; g < N_RULES; g++) begin : g_fit
        a_r7_fit_single_step: assert property (@(posedge clk) disable iff (rst)
            !wr_ok |=> ((int'(fit_vec[g]) - int'($past(fit_vec[g])) <= 1) &&
                        (int'($past(fit_vec[g])) - int'(fit_vec[g]) <= 1)));
    end

endmodule

bind ternary_action_selector tas_checker #(.N_RULES(N_RULES)) u_tas_checker (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .act_valid   (act_valid),
    .act_nomatch (act_nomatch),
    .act_rule    (act_rule),
    .hit_vec     (hit_vec),
    .fit_vec     (fit_vec),
    .mode_q      (mode_q),
    .wr_ok       (wr_ok)
);

// File: tb/test_ternary_action_selector.sv
module test_ternary_action_selector;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] mon_state;
    logic       pick_mode;
    logic       eval_go;
    logic       reward_go;
    logic       reward_pos;
    logic       wr_en;
    logic [3:0] wr_idx;
    logic [7:0] wr_value;
    logic [7:0] wr_care;
    logic [4:0] wr_action;
    logic [3:0] wr_fitness;
    logic       busy;
    logic       act_valid;
    logic       act_nomatch;
    logic [4:0] act_out;
    logic [3:0] act_rule;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [4:0] r_act;
    logic [3:0] r_rule;
    logic       r_nom;

    always #4 clk = ~clk;

    ternary_action_selector i_ternary_action_selector (
        .clk         (clk),
        .rst         (rst),
        .mon_state   (mon_state),
        .pick_mode   (pick_mode),
        .eval_go     (eval_go),
        .reward_go   (reward_go),
        .reward_pos  (reward_pos),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_value    (wr_value),
        .wr_care     (wr_care),
        .wr_action   (wr_action),
        .wr_fitness  (wr_fitness),
        .busy        (busy),
        .act_valid   (act_valid),
        .act_nomatch (act_nomatch),
        .act_out     (act_out),
        .act_rule    (act_rule)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; eval_go = 0; reward_go = 0; reward_pos = 0; wr_en = 0;
        mon_state = 0; pick_mode = 0; wr_idx = 0; wr_value = 0; wr_care = 0;
        wr_action = 0; wr_fitness = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic put_rule(input int idx, input logic [7:0] v, input logic [7:0] c,
                            input logic [4:0] a, input logic [3:0] f);
        @(negedge clk);
        wr_en = 1; wr_idx = 4'(idx); wr_value = v; wr_care = c; wr_action = a; wr_fitness = f;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic run_eval(input logic [7:0] st, input logic md);
        @(negedge clk);
        mon_state = st; pick_mode = md; eval_go = 1;
        @(negedge clk);
        eval_go = 0;
        for (int k = 0; k < 40 && !act_valid; k++) @(negedge clk);
        check(act_valid == 1'b1, "R5 result timeout", act_valid, 1);
        r_act = act_out; r_rule = act_rule; r_nom = act_nomatch;
    endtask

    task automatic give_reward(input logic pos, input int cycles);
        @(negedge clk);
        reward_go = 1; reward_pos = pos;
        repeat (cycles) @(negedge clk);
        reward_go = 0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(act_valid == 0, "R1 act_valid after reset", act_valid, 0);
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(act_out == 0, "R1 act_out after reset", act_out, 0);
        run_eval(8'hA5, 1'b0);
        check(r_nom == 1, "R1 empty table no match", r_nom, 1);
        check(r_act == 0, "R4 default action", r_act, 0);
    endtask

    task automatic t_match_and_top();
        // R9 timing: result by the second edge after eval_go
        put_rule(0, 8'b101_000_00, 8'b111_000_00, 5'h0A, 4'd5);
        put_rule(1, 8'b101_010_01, 8'hFF,         5'h13, 4'd9);
        put_rule(2, 8'h00,         8'h00,         5'h01, 4'd2);
        @(negedge clk);
        mon_state = 8'b101_010_01; pick_mode = 0; eval_go = 1;
        @(negedge clk);
        eval_go = 0;
        check(busy == 1, "R9 busy during scan", busy, 1);
        check(act_valid == 0, "R9 valid low during scan", act_valid, 0);
        @(negedge clk);
        check(act_valid == 1, "R3 result after two edges", act_valid, 1);
        check(act_out == 5'h13, "R3 highest fitness wins", act_out, 5'h13);
        check(act_rule == 1, "R3 winning index", act_rule, 1);
        run_eval(8'b101_111_10, 1'b0);
        check(r_act == 5'h0A && r_nom == 0, "R2 wildcard match", r_act, 5'h0A);
        run_eval(8'b001_010_01, 1'b0);
        check(r_act == 5'h01 && r_rule == 2, "R2 cared bit mismatch", r_rule, 2);
    endtask

    task automatic t_tie_and_reward();
        put_rule(3, 8'h00, 8'h00, 5'h1F, 4'd9);
        run_eval(8'b101_010_01, 1'b0);
        check(r_rule == 1, "R3 tie to lowest index", r_rule, 1);
        give_reward(1'b0, 1);                 // rule1 -> 8
        run_eval(8'b101_010_01, 1'b0);
        check(r_rule == 3, "R6 negative reward lowers winner", r_rule, 3);
        give_reward(1'b0, 1);                 // rule3 -> 8
        run_eval(8'b101_010_01, 1'b0);
        check(r_rule == 1, "R6 tie after decrement", r_rule, 1);
        give_reward(1'b1, 2);                 // rule1 -> 9, second strobe dropped
        run_eval(8'b101_010_01, 1'b0);
        check(r_rule == 1, "R6 positive reward", r_rule, 1);
        give_reward(1'b0, 1);                 // rule1 -> 8
        run_eval(8'b101_010_01, 1'b0);
        check(r_rule == 1, "R6 tie again", r_rule, 1);
        give_reward(1'b0, 1);                 // rule1 -> 7
        run_eval(8'b101_010_01, 1'b0);
        check(r_rule == 3, "R6 one reward per result", r_rule, 3);
    endtask

    task automatic t_saturation();
        do_reset();
        put_rule(4, 8'h3C, 8'hFF, 5'h04, 4'd15);
        put_rule(5, 8'h3C, 8'hFF, 5'h05, 4'd15);
        run_eval(8'h3C, 1'b0);
        check(r_rule == 4, "R7 top tie", r_rule, 4);
        give_reward(1'b1, 1);
        run_eval(8'h3C, 1'b0);
        check(r_rule == 4, "R7 no wrap above 15", r_rule, 4);
        give_reward(1'b0, 1);
        run_eval(8'h3C, 1'b0);
        check(r_rule == 5, "R7 decrement from 15", r_rule, 5);
        put_rule(6, 8'h55, 8'hFF, 5'h06, 4'd0);
        put_rule(7, 8'h55, 8'hFF, 5'h07, 4'd0);
        run_eval(8'h55, 1'b0);
        check(r_rule == 6, "R7 zero tie", r_rule, 6);
        give_reward(1'b0, 1);
        run_eval(8'h55, 1'b0);
        check(r_rule == 6, "R7 no wrap below 0", r_rule, 6);
    endtask

    task automatic t_write_while_busy();
        @(negedge clk);
        mon_state = 8'h55; pick_mode = 0; eval_go = 1;
        @(negedge clk);
        eval_go = 0;
        wr_en = 1; wr_idx = 4'd6; wr_value = 8'h55; wr_care = 8'hFF;
        wr_action = 5'h1E; wr_fitness = 4'd15;
        @(negedge clk);
        wr_en = 0;
        for (int k = 0; k < 40 && !act_valid; k++) @(negedge clk);
        run_eval(8'h55, 1'b0);
        check(r_act == 5'h06, "R8 write ignored while busy", r_act, 5'h06);
        check(r_rule == 6, "R8 fitness kept while busy", r_rule, 6);
    endtask

    task automatic t_wheel();
        int c0 = 0;
        int c1 = 0;
        int c2 = 0;
        int nom = 0;
        do_reset();
        put_rule(0, 8'hA0, 8'hF0, 5'h0C, 4'd12);
        put_rule(1, 8'hA0, 8'hF0, 5'h11, 4'd0);
        put_rule(2, 8'hA5, 8'hFF, 5'h04, 4'd4);
        put_rule(3, 8'h0F, 8'hFF, 5'h03, 4'd0);
        for (int n = 0; n < 60; n++) begin
            run_eval(8'hA5, 1'b1);
            if (r_nom) nom++;
            else if (r_rule == 0) c0++;
            else if (r_rule == 1) c1++;
            else if (r_rule == 2) c2++;
            repeat (n % 3) @(negedge clk);
        end
        check(nom == 0, "R5 wheel always finds a rule", nom, 0);
        check(c1 == 0, "R5 zero fitness never drawn", c1, 0);
        check(c0 > 0, "R5 heavy rule drawn", c0, 1);
        check(c2 > 0, "R5 light rule drawn", c2, 1);
        check(c0 > c2, "R5 weighting favours fitness", c0, c2);
        check(c0 + c2 == 60, "R5 picks are matching rules", c0 + c2, 60);
        run_eval(8'h0F, 1'b1);
        check(r_nom == 1 && r_act == 0, "R4 zero total gives no match", r_nom, 1);
        run_eval(8'h0F, 1'b0);
        check(r_nom == 0 && r_rule == 3, "R3 zero fitness eligible by top pick", r_rule, 3);
    endtask

    initial begin
        t_reset_state();
        t_match_and_top();
        t_tie_and_reward();
        t_saturation();
        t_write_while_busy();
        t_wheel();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule